// File: doc/BRIEF.md
# Voltage Sag and Peak Detector

This block watches the signed voltage and current samples of a three-phase metering path. For each phase it follows the largest voltage magnitude seen between two zero crossings of that phase. When that half-cycle maximum stays under a shared sag level for a shared number of consecutive half cycles, it raises a one-cycle sag event for that phase. A sag event is raised once per episode. The phase can only raise another one after a half cycle at or above the level has been seen.

Separately, one channel (the voltage or current of one phase) is picked for peak watching. Every valid sample on that channel is compared against a voltage or current peak level, and a one-cycle peak event is raised when the level is exceeded. The event outputs are meant to feed an interrupt status register, which does its own masking.

All levels are 8 bits wide. They are compared with the upper 8 bits of the sample magnitude, so a level keeps its meaning whatever the sample width is.

Top module: `sag_peak_monitor`

## Requirements
- R1: The magnitude code of a sample is bits [SAMPLE_W-2:SAMPLE_W-9] of its absolute value. The most negative sample saturates to the largest positive magnitude, which gives a code of 255.
- R2: `peak_o` pulses high for one cycle, one clock after a cycle with `smp_valid_i`=1 in which the magnitude code of the selected channel is strictly greater than its level. Channel select 0 picks voltage and uses `v_pk_lvl_i`. Channel select 1 picks current and uses `i_pk_lvl_i`.
- R3: `pk_phase_sel_i` values 0..NUM_PH-1 pick the phase (phase p sits at bits [p*SAMPLE_W +: SAMPLE_W]). Any larger value disables peak events. Samples on channels that are not selected never raise `peak_o`.
- R4: Each phase keeps the maximum voltage magnitude code seen since its last zero-crossing strobe. A valid sample arriving in the same cycle as that phase's strobe counts toward the new half cycle.
- R5: At a phase's strobe, the half cycle just ended is "low" if its maximum is strictly below `sag_lvl_i`. A low half cycle increments that phase's counter, which saturates at 255. Any other half cycle clears the counter to 0.
- R6: `sag_o[p]` pulses for one cycle, one clock after the strobe at which the counter reaches `sag_cyc_i`. A count of 0 acts as 1.
- R7: After a sag pulse, phase p pulses no more until a half cycle that is not low has ended.
- R8: All phases share `sag_lvl_i` and `sag_cyc_i`, but each phase advances only on its own `zx_i` bit.
- R9: While `rst_ni` is low, both outputs are low. After reset, every counter and every half-cycle maximum is 0, and every phase is ready to fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | All sample inputs are valid this cycle |
| v_smp_i | input | NUM_PH*SAMPLE_W | Signed voltage samples, one per phase |
| i_smp_i | input | NUM_PH*SAMPLE_W | Signed current samples, one per phase |
| zx_i | input | NUM_PH | Per-phase zero-crossing strobe |
| sag_lvl_i | input | 8 | Shared sag level |
| sag_cyc_i | input | 8 | Shared sag duration in half cycles |
| v_pk_lvl_i | input | 8 | Voltage peak level |
| i_pk_lvl_i | input | 8 | Current peak level |
| pk_phase_sel_i | input | SEL_W | Phase picked for peak watching |
| pk_chan_sel_i | input | 1 | 0 = voltage, 1 = current |
| sag_o | output | NUM_PH | Per-phase sag event pulse |
| peak_o | output | 1 | Peak event pulse |

## Verification
The bench builds the block with SAMPLE_W=12 and NUM_PH=3. This makes the whole signed sample range of 4096 values small enough to sweep exhaustively through the magnitude and peak compare, including the saturating most negative code and the strict-greater edge at each level.

The small width also keeps half-cycle sequences short. This brings the counter saturation at a duration of 255, the zero duration, re-arming, and independent per-phase strobes within a few thousand cycles.

A per-cycle model, written from the requirements, predicts every sag and peak pulse.

// File: rtl/sag_peak_pkg.sv
package sag_peak_pkg;
  localparam int LVL_W = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic {CH_VOLT = 1'b0, CH_CURR = 1'b1} chan_e;
endpackage

// File: rtl/mag_code.sv
module mag_code
  import sag_peak_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  output lvl_t                code_o
);
  logic [SAMPLE_W-1:0] absv;
  logic [SAMPLE_W-2:0] mag;

  always_comb begin
    absv = smp_i[SAMPLE_W-1] ? (~smp_i + 1'b1) : smp_i;
    // only the most negative value leaves the MSB set: saturate
    mag  = absv[SAMPLE_W-1] ? '1 : absv[SAMPLE_W-2:0];
  end

  assign code_o = mag[SAMPLE_W-2 -: LVL_W];
endmodule

// File: rtl/sag_tracker.sv
module sag_tracker
  import sag_peak_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic zx_i,
  input  lvl_t code_i,
  input  lvl_t lvl_i,
  input  lvl_t cyc_i,
  output logic sag_o
);
  lvl_t hc_pk_q, cnt_q, cnt_nxt;
  logic armed_q, sag_q, low_hc, reach;

  always_comb begin
    low_hc  = hc_pk_q < lvl_i;
    cnt_nxt = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    reach   = ({1'b0, cnt_q} + 9'd1) >= {1'b0, cyc_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_pk_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      sag_q   <= 1'b0;
    end else begin
      sag_q <= 1'b0;
      if (zx_i) begin
        hc_pk_q <= valid_i ? code_i : '0;
        if (low_hc) begin
          cnt_q <= cnt_nxt;
          if (armed_q && reach) begin
            sag_q   <= 1'b1;
            armed_q <= 1'b0;
          end
        end else begin
          cnt_q   <= '0;
          armed_q <= 1'b1;
        end
      end else if (valid_i && code_i > hc_pk_q) begin
        hc_pk_q <= code_i;
      end
    end
  end

  assign sag_o = sag_q;

  a_r6_sag_after_zx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sag_q |-> $past(zx_i));
  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zx_i && low_hc && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 8'd1));
  a_r5_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zx_i && !low_hc) |=> (cnt_q == '0));
  a_r7_rearm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(zx_i && hc_pk_q >= lvl_i));
endmodule

// File: rtl/peak_checker.sv
module peak_checker
  import sag_peak_pkg::*;
#(
  parameter int NUM_PH = 3,
  parameter int SEL_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  lvl_t [NUM_PH-1:0]       v_code_i,
  input  lvl_t [NUM_PH-1:0]       i_code_i,
  input  lvl_t                    v_lvl_i,
  input  lvl_t                    i_lvl_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    chan_i,
  output logic                    peak_o
);
  logic sel_ok, hit, peak_q;
  lvl_t cand, thr;
  logic [SEL_W-1:0] idx;

  always_comb begin
    sel_ok = int'(sel_i) < NUM_PH;
    idx    = sel_ok ? sel_i : '0;
    cand   = (chan_e'(chan_i) == CH_CURR) ? i_code_i[idx] : v_code_i[idx];
    thr    = (chan_e'(chan_i) == CH_CURR) ? i_lvl_i : v_lvl_i;
    hit    = valid_i && sel_ok && (cand > thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) peak_q <= 1'b0;
    else         peak_q <= hit;
  end

  assign peak_o = peak_q;

  a_r2_peak_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_q |-> $past(valid_i));
  a_r3_peak_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_q |-> $past(int'(sel_i) < NUM_PH));
endmodule

// File: rtl/sag_peak_monitor.sv
module sag_peak_monitor
  import sag_peak_pkg::*;
#(
  parameter int NUM_PH   = 3,
  parameter int SAMPLE_W = 24,
  localparam int SEL_W   = $clog2(NUM_PH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_valid_i,
  input  logic [NUM_PH*SAMPLE_W-1:0] v_smp_i,
  input  logic [NUM_PH*SAMPLE_W-1:0] i_smp_i,
  input  logic [NUM_PH-1:0]          zx_i,
  input  logic [7:0]                 sag_lvl_i,
  input  logic [7:0]                 sag_cyc_i,
  input  logic [7:0]                 v_pk_lvl_i,
  input  logic [7:0]                 i_pk_lvl_i,
  input  logic [SEL_W-1:0]           pk_phase_sel_i,
  input  logic                       pk_chan_sel_i,
  output logic [NUM_PH-1:0]          sag_o,
  output logic                       peak_o
);
  lvl_t [NUM_PH-1:0] v_code, i_code;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    mag_code #(.SAMPLE_W(SAMPLE_W)) u_vmag (
      .smp_i (v_smp_i[p*SAMPLE_W +: SAMPLE_W]),
      .code_o(v_code[p])
    );
    mag_code #(.SAMPLE_W(SAMPLE_W)) u_imag (
      .smp_i (i_smp_i[p*SAMPLE_W +: SAMPLE_W]),
      .code_o(i_code[p])
    );
    sag_tracker u_sag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(smp_valid_i),
      .zx_i   (zx_i[p]),
      .code_i (v_code[p]),
      .lvl_i  (sag_lvl_i),
      .cyc_i  (sag_cyc_i),
      .sag_o  (sag_o[p])
    );
  end

  peak_checker #(.NUM_PH(NUM_PH), .SEL_W(SEL_W)) u_peak (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .v_code_i(v_code),
    .i_code_i(i_code),
    .v_lvl_i (v_pk_lvl_i),
    .i_lvl_i (i_pk_lvl_i),
    .sel_i   (pk_phase_sel_i),
    .chan_i  (pk_chan_sel_i),
    .peak_o  (peak_o)
  );

  a_r9_idle_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (sag_o == '0 && !peak_o));
endmodule

// File: tb/sag_peak_monitor_tb_top.sv
module sag_peak_monitor_tb_top;
  localparam int NPH = 3;
  localparam int W   = 12;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, chan = 1'b0;
  logic [NPH*W-1:0] vs = '0, is = '0;
  logic [NPH-1:0] zx = '0, sag;
  logic [7:0] slvl = '0, scyc = '0, vpk = '0, ipk = '0;
  logic [1:0] psel = '0;
  logic peak;

  int checks = 0, errors = 0;
  int m_pk[NPH], m_cnt[NPH];
  bit m_arm[NPH];

  always #2 clk = ~clk;

  sag_peak_monitor #(.NUM_PH(NPH), .SAMPLE_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .v_smp_i(vs), .i_smp_i(is),
    .zx_i(zx), .sag_lvl_i(slvl), .sag_cyc_i(scyc), .v_pk_lvl_i(vpk), .i_pk_lvl_i(ipk),
    .pk_phase_sel_i(psel), .pk_chan_sel_i(chan), .sag_o(sag), .peak_o(peak));

  function automatic int code_of(int v);
    int m = (v < 0) ? -v : v;
    if (m > (1 << (W-1)) - 1) m = (1 << (W-1)) - 1;
    return m >> (W-9);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NPH; p++) begin m_pk[p] = 0; m_cnt[p] = 0; m_arm[p] = 1; end
  endtask

  task automatic cyc(bit v, bit [2:0] z, int v0, int v1, int v2, int i0, int i1, int i2,
                     string tag);
    int va[NPH], ia[NPH], c, lim, e_pk;
    bit [NPH-1:0] e_sag;
    va[0] = v0; va[1] = v1; va[2] = v2; ia[0] = i0; ia[1] = i1; ia[2] = i2;
    valid = v; zx = z;
    for (int p = 0; p < NPH; p++) begin
      vs[p*W +: W] = W'(va[p]);
      is[p*W +: W] = W'(ia[p]);
    end
    e_sag = '0;
    lim = (int'(scyc) == 0) ? 1 : int'(scyc);
    for (int p = 0; p < NPH; p++) begin
      c = code_of(va[p]);
      if (z[p]) begin
        if (m_pk[p] < int'(slvl)) begin
          if (m_cnt[p] < 255) m_cnt[p]++;
          if (m_arm[p] && m_cnt[p] >= lim) begin e_sag[p] = 1'b1; m_arm[p] = 0; end
        end else begin
          m_cnt[p] = 0; m_arm[p] = 1;
        end
        m_pk[p] = v ? c : 0;
      end else if (v && c > m_pk[p]) m_pk[p] = c;
    end
    e_pk = 0;
    if (v && int'(psel) < NPH)
      e_pk = chan ? int'(code_of(ia[psel]) > int'(ipk)) : int'(code_of(va[psel]) > int'(vpk));
    @(negedge clk);
    chk({tag, " R5 R6 R7 R8 sag_o"}, int'(sag), int'(e_sag));
    chk({tag, " R1 R2 R3 peak_o"}, int'(peak), e_pk);
  endtask

  function automatic int amp(int a, int k);
    return (k % 2) ? -(a * 8 + 5) : (a * 8 + 2);
  endfunction

  // three sample cycles then a strobe cycle that also carries a sample
  task automatic half(int a0, int a1, int a2, bit [2:0] z, string tag);
    for (int k = 0; k < 3; k++)
      cyc(1, 3'b000, amp(a0, k), amp(a1, k), amp(a2, k), 0, 0, 0, tag);
    cyc(1, z, amp(a0, 3), amp(a1, 3), amp(a2, 3), 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R9 reset sag_o", int'(sag), 0);
    chk("R9 reset peak_o", int'(peak), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset sag_o", int'(sag), 0);

    // R1 R2 R3: full sweep of phase 1 voltage, other phases at max magnitude
    vpk = 8'd37; ipk = 8'd200; psel = 2'd1; chan = 1'b0;
    for (int v = -2048; v < 2048; v++) cyc(1, 0, 2047, v, -2048, 2047, 2047, 2047, "R1 sweep volt");
    chan = 1'b1; psel = 2'd2;
    for (int v = -2048; v < 2048; v += 3) cyc(1, 0, 2047, 2047, 2047, 2047, 2047, v, "R2 sweep curr");
    chan = 1'b0; psel = 2'd0; vpk = 8'd0;
    for (int v = -2048; v < 2048; v += 5) cyc(1, 0, v, 2047, 2047, 0, 0, 0, "R2 level zero");
    vpk = 8'd255;
    for (int v = -2048; v < 2048; v += 5) cyc(1, 0, v, 0, 0, 0, 0, 0, "R2 level max");
    vpk = 8'd0; psel = 2'd3;
    for (int k = 0; k < 8; k++) cyc(1, 0, 2047, 2047, 2047, 2047, 2047, 2047, "R3 disabled");
    psel = 2'd0;
    cyc(0, 0, 2047, 2047, 2047, 2047, 2047, 2047, "R2 no valid");

    // sag sequences: reset trackers first
    rst_n = 1'b0; model_reset(); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    slvl = 8'd50; scyc = 8'd3; vpk = 8'd255; ipk = 8'd255;
    for (int h = 0; h < 14; h++)
      half((h == 6) ? 90 : 20, 60, (h < 4) ? 50 : 49, 3'b111, "R5 shared level");
    // R8: only phase 0 strobes
    for (int h = 0; h < 6; h++) half(60, 10, 10, 3'b001, "R8 own strobe");
    for (int h = 0; h < 6; h++) half(10, 10, 10, 3'b001, "R8 own strobe low");
    // R6: duration 0 and 1
    scyc = 8'd0;
    for (int h = 0; h < 4; h++) half(h == 2 ? 80 : 5, 80, 80, 3'b111, "R6 dur0");
    scyc = 8'd1;
    for (int h = 0; h < 4; h++) half(h == 1 ? 80 : 5, 5, 80, 3'b111, "R6 dur1");
    // R4: big sample in strobe cycle belongs to new half cycle
    cyc(1, 3'b000, 8, 8, 8, 0, 0, 0, "R4 carry");
    cyc(1, 3'b111, 2047, 8, 8, 0, 0, 0, "R4 carry");
    cyc(1, 3'b000, 8, 8, 8, 0, 0, 0, "R4 carry");
    cyc(1, 3'b111, 8, 8, 8, 0, 0, 0, "R4 carry");
    // R5: saturation with duration 255
    half(90, 90, 90, 3'b111, "R5 sat prep");
    scyc = 8'd255;
    for (int h = 0; h < 260; h++) half(3, 3, 90, 3'b111, "R5 saturate");
    half(90, 3, 90, 3'b111, "R7 rearm");
    for (int h = 0; h < 3; h++) half(3, 3, 3, 3'b111, "R7 after rearm");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule